// File: doc/BRIEF.md
# Snooze Mode Sequencer

This block controls how a synchronous memory enters and leaves its low-power snooze state. The sleep request comes from outside the clock domain, is asynchronous and active high. The block first passes it through a flop synchroniser. A four-state machine then applies fixed entry and exit intervals. While the memory is entering, sleeping or recovering, the block drives a signal that blocks every other input. It also forces the data bus to three-state from the moment the synchronised request is seen until the memory is fully awake again.

The block polices how the surrounding logic uses the memory around sleep, and reports misuse on a sticky violation flag that only reset clears. There are three kinds of misuse. The first is a request that arrives while the device is still selected. The second is an access attempted during entry; that access is dropped. The third is any chip-enable or strobe activity during the recovery window. Activity while fully asleep is ignored. The caller supplies two qualified activity inputs: one says the device is selected, the other says an address strobe is active.

Top module: `snz_seq`

## Requirements
- R1: After reset, `sleep_o`, `block_o`, `bus_hiz_o` and `viol_o` are all 0.
- R2: A change on `sleep_req_i` becomes visible inside the block only after `SYNC_STAGES` (default 2) rising edges. `bus_hiz_o` therefore rises after the second edge and not after the first.
- R3: On the edge after the synchronised request is seen, the block enters the entry state and `block_o` goes to 1. `sleep_o` goes to 1 exactly `ENTRY_CYCLES` (default 2) edges later.
- R4: While asleep, `sel_i` and `strobe_i` are ignored: `sleep_o` stays 1 and `viol_o` stays 0.
- R5: Once the synchronised request is low while asleep, `sleep_o` falls on the next edge. `block_o` then stays 1 for `EXIT_CYCLES` (default 2) cycles of recovery before it returns to 0.
- R6: `bus_hiz_o` is 1 whenever `block_o` is 1 or the synchronised request is 1. It is 0 once the block is awake with the request low.
- R7: Any `sel_i` or `strobe_i` activity during recovery sets `viol_o` on the next edge. `viol_o` stays set until reset.
- R8: If the synchronised request is seen while `sel_i` is 1, `viol_o` is set, and entry proceeds anyway.
- R9: An access (`sel_i` and `strobe_i` both 1) during entry is dropped and sets `viol_o`. Entry still completes on time.
- R10: If the synchronised request rises again during recovery, the block returns to the entry state without first becoming awake. `block_o` stays 1 throughout.
- R11: If the request drops during entry, entry still completes: `sleep_o` is 1 for one cycle, and recovery follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_req_i | input | 1 | Asynchronous sleep request, active high |
| sel_i | input | 1 | All chip enables active (device selected) |
| strobe_i | input | 1 | Either address strobe active |
| sleep_o | output | 1 | Memory is in the snooze state |
| block_o | output | 1 | Block all other memory inputs |
| bus_hiz_o | output | 1 | Force the data bus to three-state |
| viol_o | output | 1 | Sticky protocol violation flag |

## Verification
A wrong internal state shows up first on `block_o` and `sleep_o`. If the state machine skips entry or recovery, or miscounts an interval, `sleep_o` moves one or more edges off its expected edge, or `block_o` drops while recovery should still hold it. A synchroniser with the wrong depth moves `bus_hiz_o` by a whole cycle relative to the request. A fault in the policer appears on `viol_o` one edge after the offending cycle, and it persists because the flag is sticky.

// File: rtl/snz_pkg.sv
package snz_pkg;

    typedef enum logic [1:0] {
        SNZ_AWAKE   = 2'd0,
        SNZ_ENTER   = 2'd1,
        SNZ_ASLEEP  = 2'd2,
        SNZ_RECOVER = 2'd3
    } snz_state_e;

endpackage

// File: rtl/snz_sync.sv
module snz_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);

    logic [SYNC_STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[SYNC_STAGES-2:0], async_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= chain_d;
    end

    assign sync_o = chain_q[SYNC_STAGES-1];

    // R2: the output only follows the stage in front of it
    assert_sync_shift_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (sync_o == $past(chain_q[SYNC_STAGES-2])));

endmodule

// File: rtl/snz_fsm.sv
module snz_fsm
    import snz_pkg::*;
#(
    parameter int ENTRY_CYCLES = 2,
    parameter int EXIT_CYCLES  = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       req_s_i,
    output snz_state_e state_o
);

    localparam int MAX_CYC = (ENTRY_CYCLES > EXIT_CYCLES) ? ENTRY_CYCLES : EXIT_CYCLES;
    localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
    localparam logic [CNT_W-1:0] ENTRY_LAST = CNT_W'(ENTRY_CYCLES - 1);
    localparam logic [CNT_W-1:0] EXIT_LAST  = CNT_W'(EXIT_CYCLES - 1);

    typedef struct packed {
        snz_state_e       st;
        logic [CNT_W-1:0] cnt;
    } fsm_s;

    fsm_s r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            SNZ_AWAKE: begin
                if (req_s_i) begin
                    r_d.st  = SNZ_ENTER;
                    r_d.cnt = '0;
                end
            end
            SNZ_ENTER: begin
                if (r_q.cnt == ENTRY_LAST) begin
                    r_d.st  = SNZ_ASLEEP;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = r_q.cnt + CNT_W'(1);
                end
            end
            SNZ_ASLEEP: begin
                if (!req_s_i) begin
                    r_d.st  = SNZ_RECOVER;
                    r_d.cnt = '0;
                end
            end
            SNZ_RECOVER: begin
                if (req_s_i) begin
                    r_d.st  = SNZ_ENTER;
                    r_d.cnt = '0;
                end else if (r_q.cnt == EXIT_LAST) begin
                    r_d.st  = SNZ_AWAKE;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = r_q.cnt + CNT_W'(1);
                end
            end
            default: r_d = '{st: SNZ_AWAKE, cnt: '0};
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '{st: SNZ_AWAKE, cnt: '0};
        else         r_q <= r_d;
    end

    assign state_o = r_q.st;

    // R3: sleep is reached only through the entry state
    assert_sleep_via_entry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(r_q.st == SNZ_ASLEEP) |-> ($past(r_q.st) == SNZ_ENTER));

    // R11: entry is never abandoned before its count completes
    assert_entry_holds_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.st == SNZ_ENTER && r_q.cnt != ENTRY_LAST) |=> (r_q.st == SNZ_ENTER));

    // R5: leaving sleep always passes through recovery
    assert_exit_via_recover_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(r_q.st == SNZ_ASLEEP) |-> (r_q.st == SNZ_RECOVER));

endmodule

// File: rtl/snz_policer.sv
module snz_policer
    import snz_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  snz_state_e state_i,
    input  logic       req_s_i,
    input  logic       sel_i,
    input  logic       strobe_i,
    output logic       viol_o
);

    typedef struct packed {
        logic viol;
    } pol_s;

    pol_s r_d, r_q;
    logic set_sel_req;
    logic set_entry_acc;
    logic set_recover_act;

    always_comb begin
        set_sel_req     = (state_i == SNZ_AWAKE)   && req_s_i && sel_i;
        set_entry_acc   = (state_i == SNZ_ENTER)   && sel_i && strobe_i;
        set_recover_act = (state_i == SNZ_RECOVER) && (sel_i || strobe_i);
        r_d.viol = r_q.viol | set_sel_req | set_entry_acc | set_recover_act;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '{viol: 1'b0};
        else         r_q <= r_d;
    end

    assign viol_o = r_q.viol;

    // R7: the flag is sticky
    assert_viol_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        viol_o |=> viol_o);

    // R4: activity while asleep never raises the flag
    assert_asleep_ignored_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_i == SNZ_ASLEEP && !viol_o) |=> !viol_o);

endmodule

// File: rtl/snz_seq.sv
module snz_seq
    import snz_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int ENTRY_CYCLES = 2,
    parameter int EXIT_CYCLES  = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sleep_req_i,
    input  logic sel_i,
    input  logic strobe_i,
    output logic sleep_o,
    output logic block_o,
    output logic bus_hiz_o,
    output logic viol_o
);

    logic       req_s;
    snz_state_e state;

    snz_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (sleep_req_i),
        .sync_o  (req_s)
    );

    snz_fsm #(.ENTRY_CYCLES(ENTRY_CYCLES), .EXIT_CYCLES(EXIT_CYCLES)) fsm_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .req_s_i (req_s),
        .state_o (state)
    );

    snz_policer policer_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .state_i  (state),
        .req_s_i  (req_s),
        .sel_i    (sel_i),
        .strobe_i (strobe_i),
        .viol_o   (viol_o)
    );

    always_comb begin
        sleep_o   = (state == SNZ_ASLEEP);
        block_o   = (state != SNZ_AWAKE);
        bus_hiz_o = block_o | req_s;
    end

    // R6: the bus is still three-stated on the cycle sleep ends
    assert_exit_hiz_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(sleep_o) |-> bus_hiz_o);

    // R5: block_o falls only after recovery, never directly from sleep
    assert_block_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(block_o) |-> !$past(sleep_o));

endmodule

// File: tb/snz_seq_tb.sv
`timescale 1ns/1ps
module snz_seq_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0;
    logic sel = 1'b0;
    logic stb = 1'b0;
    logic sleep, block, hiz, viol;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    always #2.5 clk = ~clk;

    snz_seq dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .sleep_req_i (req),
        .sel_i       (sel),
        .strobe_i    (stb),
        .sleep_o     (sleep),
        .block_o     (block),
        .bus_hiz_o   (hiz),
        .viol_o      (viol)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req = 1'b0; sel = 1'b0; stb = 1'b0;
        step(2);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 sleep", sleep, 1'b0);
        chk("R1 block", block, 1'b0);
        chk("R1 hiz",   hiz,   1'b0);
        chk("R1 viol",  viol,  1'b0);
    endtask

    task automatic t_entry_exit();
        do_reset();
        req = 1'b1;
        step(1); chk("R2 hiz after one edge", hiz, 1'b0);
        step(1); chk("R2 hiz after two edges", hiz, 1'b1);
        chk("R6 hiz before block", block, 1'b0);
        step(1); chk("R3 block on entry", block, 1'b1);
        chk("R3 not yet asleep", sleep, 1'b0);
        step(1); chk("R3 entry second cycle", sleep, 1'b0);
        step(1); chk("R3 asleep", sleep, 1'b1);
        req = 1'b0;
        step(2); chk("R5 asleep during sync", sleep, 1'b1);
        step(1); chk("R5 sleep falls", sleep, 1'b0);
        chk("R5 block in recovery", block, 1'b1);
        chk("R6 hiz in recovery", hiz, 1'b1);
        step(1); chk("R5 recovery second cycle", block, 1'b1);
        step(1); chk("R5 awake", block, 1'b0);
        chk("R6 hiz released", hiz, 1'b0);
        chk("R7 no violation clean cycle", viol, 1'b0);
    endtask

    task automatic t_asleep_ignores();
        do_reset();
        req = 1'b1;
        step(5);
        sel = 1'b1; stb = 1'b1;
        step(3);
        chk("R4 still asleep", sleep, 1'b1);
        chk("R4 no violation", viol, 1'b0);
        sel = 1'b0; stb = 1'b0; req = 1'b0;
        step(5);
        chk("R4 awake, no violation", viol, 1'b0);
    endtask

    task automatic t_recover_violation();
        do_reset();
        req = 1'b1; step(5);
        req = 1'b0; step(3);
        chk("R7 in recovery", block, 1'b1);
        stb = 1'b1;
        step(1); chk("R7 strobe in recovery", viol, 1'b1);
        stb = 1'b0;
        step(4); chk("R7 sticky", viol, 1'b1);
        do_reset();
        chk("R1 reset clears viol", viol, 1'b0);
    endtask

    task automatic t_selected_request();
        do_reset();
        sel = 1'b1; req = 1'b1;
        step(2); chk("R8 not yet seen", viol, 1'b0);
        step(1); chk("R8 request while selected", viol, 1'b1);
        chk("R8 entry proceeds", block, 1'b1);
        sel = 1'b0;
        step(2); chk("R8 asleep anyway", sleep, 1'b1);
        req = 1'b0; step(5);
    endtask

    task automatic t_entry_access();
        do_reset();
        req = 1'b1; step(3);
        sel = 1'b1; stb = 1'b1;
        step(1); chk("R9 access during entry", viol, 1'b1);
        chk("R9 not yet asleep", sleep, 1'b0);
        sel = 1'b0; stb = 1'b0;
        step(1); chk("R9 entry completes", sleep, 1'b1);
        req = 1'b0; step(5);
    endtask

    task automatic t_reenter();
        do_reset();
        req = 1'b1; step(5);
        req = 1'b0; step(2);
        req = 1'b1;
        step(1); chk("R10 recovery", sleep, 1'b0);
        chk("R10 blocked", block, 1'b1);
        step(1); chk("R10 still blocked", block, 1'b1);
        step(1); chk("R10 back to entry, blocked", block, 1'b1);
        chk("R10 not asleep", sleep, 1'b0);
        step(2); chk("R10 asleep again", sleep, 1'b1);
        chk("R10 no violation", viol, 1'b0);
        req = 1'b0; step(5);
    endtask

    task automatic t_drop_in_entry();
        do_reset();
        req = 1'b1; step(3);
        req = 1'b0;
        step(2); chk("R11 entry completes", sleep, 1'b1);
        step(1); chk("R11 sleep one cycle", sleep, 1'b0);
        chk("R11 recovery", block, 1'b1);
        step(2); chk("R11 awake", block, 1'b0);
    endtask

    initial begin
        t_reset();
        t_entry_exit();
        t_asleep_ignores();
        t_recover_violation();
        t_selected_request();
        t_entry_access();
        t_reenter();
        t_drop_in_entry();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule